// File: doc/BRIEF.md
# H-Bridge Chopping Current Regulator

This block sequences the four gate enables of one H-bridge so that the winding current is held near a programmed level by fixed-frequency chopping. Every PWM period opens with the bridge driving in the commanded direction. The sense comparator is masked for a blanking window at the start of the period, which also sets the shortest on-time. After blanking, the first trip ends the drive. The bridge then decays for the rest of the period. In slow decay the current recirculates through both low-side switches. In mixed decay the bridge first reverses polarity (fast decay), and at three quarters of the period it moves to low-side braking.

A 3-bit level code selects a fraction of full-scale current. The block turns that fraction into an 8-bit reference for an external DAC, which sets the comparator threshold. Each leg passes through a programmable dead-time with both switches off whenever its state changes. All timing values are parameters counted in system clock cycles.

Top module: `pwm_chopper`

## Requirements
- R1: While enabled and driving, phase 1 gives leg 1 high and leg 2 low (gates `{leg1_hi,leg1_lo,leg2_hi,leg2_lo}` = 1001). Phase 0 gives leg 1 low and leg 2 high (0110).
- R2: When the enable is 0, all four gates are low one clock later. The period timer is held at the period start, so enabling again begins a fresh period with drive.
- R3: For the first BLANK_CYC cycles of each period the trip input is ignored, so the drive lasts at least that long.
- R4: A trip seen after blanking ends the drive, and the bridge stays in decay until the next period starts.
- R5: With decay select 0, decay turns on both low-side switches (0101).
- R6: With decay select 1, decay starts with reversed drive polarity. At cycle 3/4 of the period (period count reaching PER*3/4), it changes to both low-side switches.
- R7: During the reversed phase, an asserted near-zero input turns all four gates off.
- R8: The two switches of one leg are never on together. Every change of a leg's state has both of its switches off for at least DEAD_CYC cycles.
- R9: The reference output is round(pct*255/100) for the level code: 000→51, 001→97, 010→143, 011→181, 100→212, 101→235, 110→250, 111→255. It is 0 after reset.
- R10: The reference output changes only in the clock that starts a period.
- R11: The period is PERIOD_CYC cycles, or PERIOD_CYC/2 when DOUBLE_RATE is 1. A period that runs without a trip keeps driving across the period boundary without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable |
| phase_i | input | 1 | Drive direction |
| level_i | input | 3 | Current level code |
| decay_i | input | 1 | 0 = slow decay, 1 = mixed decay |
| trip_i | input | 1 | Sense comparator trip |
| zero_i | input | 1 | Winding current near zero |
| leg1_hi_o | output | 1 | Leg 1 high-side gate enable |
| leg1_lo_o | output | 1 | Leg 1 low-side gate enable |
| leg2_hi_o | output | 1 | Leg 2 high-side gate enable |
| leg2_lo_o | output | 1 | Leg 2 low-side gate enable |
| ref_o | output | 8 | Reference code for the DAC |

## Verification
The bench holds the trip input high from the start of a period. A design that ignored blanking would cut the drive at once, and one with an off-by-one blanking window would drop the gate a cycle early or late. The mixed-decay sequence is checked cycle by cycle, including the near-zero coast and the switch to braking at exactly three quarters of the period; a wrong threshold moves that edge. Every leg transition is checked for its dead-time gap, which catches direct high-to-low switching. The reference is checked at each period boundary for all eight codes, which catches both a wrong table entry and an update in the middle of a period.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {LEG_OFF = 2'd0, LEG_HIGH = 2'd1, LEG_LOW = 2'd2} leg_cmd_e;
  typedef enum logic [1:0] {ST_DRIVE, ST_FAST, ST_SLOW, ST_COAST} chop_st_e;

  function automatic logic [7:0] level_code(input logic [2:0] lvl);
    int pct;
    case (lvl)
      3'd0: pct = 20;
      3'd1: pct = 38;
      3'd2: pct = 56;
      3'd3: pct = 71;
      3'd4: pct = 83;
      3'd5: pct = 92;
      3'd6: pct = 98;
      default: pct = 100;
    endcase
    return 8'((pct * 255 + 50) / 100);
  endfunction
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int PER = 4000,
  localparam int CW = $clog2(PER)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          start_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(PER - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign start_o = run_i && (cnt_q == '0);
  assign last_o  = run_i && (cnt_q == LAST);
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int PER       = 4000,
  parameter int BLANK_CYC = 750,
  localparam int CW       = $clog2(PER),
  localparam int MIX_AT   = (PER * 3) / 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               phase_i,
  input  logic               decay_i,
  input  logic               trip_i,
  input  logic               zero_i,
  input  logic [CW-1:0]      cnt_i,
  input  logic               last_i,
  output leg_cmd_e [1:0]     cmd_o
);
  localparam logic [CW-1:0] BLANK_C  = CW'(BLANK_CYC);
  localparam logic [CW-1:0] MIX_LAST = CW'(MIX_AT - 1);

  chop_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!run_i || last_i) st_d = ST_DRIVE;
    else begin
      unique case (st_q)
        ST_DRIVE: if (trip_i && cnt_i >= BLANK_C)
                    st_d = (decay_i && cnt_i < MIX_LAST) ? ST_FAST : ST_SLOW;
        ST_FAST:  if (cnt_i == MIX_LAST) st_d = ST_SLOW;
                  else if (zero_i)       st_d = ST_COAST;
        ST_COAST: if (cnt_i == MIX_LAST) st_d = ST_SLOW;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_DRIVE;
    else         st_q <= st_d;
  end

  // leg 1 is cmd_o[0], leg 2 is cmd_o[1]
  always_comb begin
    cmd_o = {LEG_OFF, LEG_OFF};
    if (run_i) begin
      unique case (st_q)
        ST_DRIVE: cmd_o = phase_i ? {LEG_LOW, LEG_HIGH} : {LEG_HIGH, LEG_LOW};
        ST_FAST:  cmd_o = phase_i ? {LEG_HIGH, LEG_LOW} : {LEG_LOW, LEG_HIGH};
        ST_SLOW:  cmd_o = {LEG_LOW, LEG_LOW};
        default:  cmd_o = {LEG_OFF, LEG_OFF};
      endcase
    end
  end
endmodule

// File: rtl/chop_leg.sv
module chop_leg
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 4,
  localparam int DW      = $clog2(DEAD_CYC + 2)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  leg_cmd_e cmd_i,
  output logic     hi_o,
  output logic     lo_o
);
  leg_cmd_e       cur_q;
  logic [DW-1:0]  dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= LEG_OFF;
      dly_q <= '0;
    end else begin
      if (dly_q != '0) dly_q <= dly_q - 1'b1;
      if (cmd_i != cur_q) begin
        if (cur_q != LEG_OFF) begin
          cur_q <= LEG_OFF;
          dly_q <= DW'(DEAD_CYC);
        end else if (dly_q == '0) begin
          cur_q <= cmd_i;
        end
      end
    end
  end

  assign hi_o = (cur_q == LEG_HIGH);
  assign lo_o = (cur_q == LEG_LOW);
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC  = 4000,
  parameter bit DOUBLE_RATE = 1'b0,
  parameter int BLANK_CYC   = 750,
  parameter int DEAD_CYC    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       phase_i,
  input  logic [2:0] level_i,
  input  logic       decay_i,
  input  logic       trip_i,
  input  logic       zero_i,
  output logic       leg1_hi_o,
  output logic       leg1_lo_o,
  output logic       leg2_hi_o,
  output logic       leg2_lo_o,
  output logic [7:0] ref_o
);
  localparam int PER = DOUBLE_RATE ? PERIOD_CYC / 2 : PERIOD_CYC;
  localparam int CW  = $clog2(PER);

  logic [CW-1:0]  cnt;
  logic           period_start, period_last;
  leg_cmd_e [1:0] cmd;
  logic [1:0]     hi, lo;
  logic [7:0]     ref_q;

  chop_timer #(.PER(PER)) u_timer (
    .clk_i, .rst_ni, .run_i(en_i),
    .cnt_o(cnt), .start_o(period_start), .last_o(period_last)
  );

  chop_seq #(.PER(PER), .BLANK_CYC(BLANK_CYC)) u_seq (
    .clk_i, .rst_ni, .run_i(en_i), .phase_i, .decay_i, .trip_i, .zero_i,
    .cnt_i(cnt), .last_i(period_last), .cmd_o(cmd)
  );

  for (genvar g = 0; g < 2; g++) begin : g_leg
    chop_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i, .rst_ni, .cmd_i(cmd[g]), .hi_o(hi[g]), .lo_o(lo[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ref_q <= '0;
    else if (period_start) ref_q <= level_code(level_i);
  end

  assign {leg1_hi_o, leg2_hi_o} = {hi[0], hi[1]};
  assign {leg1_lo_o, leg2_lo_o} = {lo[0], lo[1]};
  assign ref_o = ref_q;
endmodule

// File: rtl/pwm_chopper_chk.sv
module pwm_chopper_chk #(
  parameter int DEAD_CYC = 4,
  localparam int RW      = $clog2(DEAD_CYC + 2)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [1:0] hi,
  input logic [1:0] lo,
  input logic       start_i,
  input logic [7:0] ref_o
);
  localparam logic [RW-1:0] DEAD_C = RW'(DEAD_CYC);

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic [RW-1:0] off_run;
    logic [1:0]    side_q; // 0 none, 1 high, 2 low

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        off_run <= '0;
        side_q  <= 2'd0;
      end else begin
        if (hi[g] || lo[g]) off_run <= '0;
        else if (off_run != DEAD_C) off_run <= off_run + 1'b1;
        if (hi[g])      side_q <= 2'd1;
        else if (lo[g]) side_q <= 2'd2;
      end
    end

    assert_leg_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hi[g] && lo[g]));
    assert_dead_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(hi[g]) && side_q == 2'd2) |-> off_run >= DEAD_C);
    assert_dead_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(lo[g]) && side_q == 2'd1) |-> off_run >= DEAD_C);
  end

  assert_disable_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (hi == 2'b00 && lo == 2'b00));
  assert_ref_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> $stable(ref_o));
endmodule

bind pwm_chopper pwm_chopper_chk #(.DEAD_CYC(DEAD_CYC)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .hi(hi), .lo(lo),
  .start_i(period_start), .ref_o(ref_o)
);

// File: tb/test_pwm_chopper.sv
`timescale 1ns/1ps
module test_pwm_chopper;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, phase = 0, decay = 0, trip = 0, zero = 0;
  logic [2:0] level = 0;
  logic l1h, l1l, l2h, l2l;
  logic [7:0] ref_code;
  int cyc = 0, n_cmp = 0, n_bad = 0;

  typedef struct {
    int         at;
    logic [3:0] g;
    logic [7:0] r;
    bit         chk_g;
    bit         chk_r;
    string      tag;
  } exp_t;
  exp_t q[$];

  pwm_chopper #(.PERIOD_CYC(128), .DOUBLE_RATE(1'b1), .BLANK_CYC(8), .DEAD_CYC(2)) i_pwm_chopper (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .phase_i(phase), .level_i(level),
    .decay_i(decay), .trip_i(trip), .zero_i(zero),
    .leg1_hi_o(l1h), .leg1_lo_o(l1l), .leg2_hi_o(l2h), .leg2_lo_o(l2l), .ref_o(ref_code)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] exp_code(input int k);
    case (k)
      0: return 8'd51;   1: return 8'd97;   2: return 8'd143;  3: return 8'd181;
      4: return 8'd212;  5: return 8'd235;  6: return 8'd250;  default: return 8'd255;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, expv);
    end
  endtask

  task automatic push(input int at, input logic [3:0] g, input bit cg,
                      input logic [7:0] r, input bit cr, input string tag);
    exp_t e;
    e.at = at; e.g = g; e.r = r; e.chk_g = cg; e.chk_r = cr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int x);
    while (cyc < x) @(negedge clk);
  endtask

  // monitor: compares due expectations away from the active edge
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      if (e.at != cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s missed slot: actual cycle %0d expected %0d", e.tag, cyc, e.at);
      end else begin
        if (e.chk_g) cmp(e.tag, {4'b0, l1h, l1l, l2h, l2l}, {4'b0, e.g});
        if (e.chk_r) cmp(e.tag, ref_code, e.r);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n0, n1, n2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R9 reset ref", ref_code, 8'd0);
    cmp("R2 reset gates", {4'b0, l1h, l1l, l2h, l2l}, 8'd0);

    // slow decay, trip held from period start
    wait_cyc(cyc + 2);
    n0 = cyc;
    push(n0 + 1,  4'b1001, 1, 8'd181, 1, "R1 R9 phase1 drive");
    push(n0 + 9,  4'b1001, 1, 0, 0, "R3 blanking holds drive");
    push(n0 + 10, 4'b0001, 1, 0, 0, "R8 dead-time after trip");
    push(n0 + 12, 4'b0001, 1, 0, 0, "R8 dead-time length");
    push(n0 + 13, 4'b0101, 1, 0, 0, "R5 slow decay brake");
    push(n0 + 40, 4'b0101, 1, 0, 0, "R4 decay held to period end");
    push(n0 + 64, 4'b0101, 1, 8'd181, 1, "R10 ref held mid period");
    push(n0 + 65, 4'b0001, 1, 8'd255, 1, "R11 R10 new period");
    push(n0 + 68, 4'b1001, 1, 0, 0, "R11 drive restarts");
    push(n0 + 71, 4'b0000, 1, 8'd255, 1, "R2 disable");
    phase = 1; decay = 0; level = 3'd3; trip = 1; en = 1;
    wait_cyc(n0 + 30); level = 3'd7;
    wait_cyc(n0 + 70); en = 0; trip = 0;

    // mixed decay with near-zero coast, then without
    wait_cyc(n0 + 80);
    n1 = cyc;
    push(n1 + 1,   4'b0110, 1, 8'd51, 1, "R1 R9 phase0 drive");
    push(n1 + 21,  4'b0110, 1, 0, 0, "R4 drive until trip");
    push(n1 + 22,  4'b0000, 1, 0, 0, "R8 both legs off");
    push(n1 + 25,  4'b1001, 1, 0, 0, "R6 reversed fast decay");
    push(n1 + 31,  4'b1001, 1, 0, 0, "R6 fast decay held");
    push(n1 + 32,  4'b0000, 1, 0, 0, "R7 coast at zero current");
    push(n1 + 48,  4'b0000, 1, 0, 0, "R7 coast held");
    push(n1 + 49,  4'b0101, 1, 0, 0, "R6 brake at 3/4");
    push(n1 + 65,  4'b0100, 1, 0, 0, "R8 leg2 dead-time");
    push(n1 + 68,  4'b0110, 1, 0, 0, "R1 drive period 2");
    push(n1 + 76,  4'b0000, 1, 0, 0, "R8 off before reverse");
    push(n1 + 79,  4'b1001, 1, 0, 0, "R6 reverse period 2");
    push(n1 + 112, 4'b1001, 1, 0, 0, "R6 fast until 3/4");
    push(n1 + 113, 4'b0001, 1, 0, 0, "R8 leg1 off before brake");
    push(n1 + 116, 4'b0101, 1, 0, 0, "R6 brake after 3/4");
    push(n1 + 121, 4'b0000, 1, 0, 0, "R2 disable again");
    phase = 0; decay = 1; level = 3'd0; trip = 0; zero = 0; en = 1;
    wait_cyc(n1 + 20); trip = 1;
    wait_cyc(n1 + 21); trip = 0;
    wait_cyc(n1 + 30); zero = 1;
    wait_cyc(n1 + 31); zero = 0;
    wait_cyc(n1 + 74); trip = 1;
    wait_cyc(n1 + 75); trip = 0;
    wait_cyc(n1 + 120); en = 0;

    // untripped periods: seamless drive, every level code
    wait_cyc(n1 + 130);
    n2 = cyc;
    push(n2 + 1, 4'b1001, 1, exp_code(0), 1, "R9 code 000");
    for (int k = 1; k < 8; k++) begin
      push(n2 + 64 * k,     4'b1001, 1, exp_code(k - 1), 1, "R10 R11 before boundary");
      push(n2 + 64 * k + 1, 4'b1001, 1, exp_code(k),     1, "R9 R11 after boundary");
    end
    phase = 1; decay = 0; level = 3'd0; trip = 0; en = 1;
    for (int k = 1; k < 8; k++) begin
      wait_cyc(n2 + 64 * k - 30);
      level = 3'(k);
    end
    wait_cyc(n2 + 64 * 7 + 5);
    while (q.size() > 0) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule